// File: doc/BRIEF.md
# Tile Static Routing Fabric

This block is the local wiring layer of one square tile of processing cells. The default tile is four by four. Every cell has two output ports and two input ports. Each port bundle carries an 8-bit data word, an 8-bit address word, a valid flag travelling forward and a ready flag travelling back.

The fabric keeps one routing entry for every cell input port. Each entry is an enable bit plus a 4-bit source code. The code names one output port of a nearby upstream cell. Links point one way only. A source is always found to the west, to the north, on one of the two northern diagonals, or two steps away along a row or a column. Offsets past a tile edge wrap to the opposite edge.

Entries are written only during a configuration phase, while `cfg_mode` is high. Writes made at any other time are dropped, so the routing stays fixed while the cells process data. The forward path is purely combinational. The ready flag of each source output port is the AND of the ready flags of every input port that currently selects it. The configuration software is expected to give each output port at most two listeners.

Top module: `quad_route_fabric`

## Requirements
- R1: After reset every routing entry is disabled. All destination ports then show zero data, zero address and valid low, and every source ready is high.
- R2: A write lands at a rising clock edge where `cfg_mode` and `cfg_we` are both high. Entry `cfg_addr` then takes `cfg_wdata`. The index is cell*2+port, and cell is row*COLS+col. Bit 4 of the data is the enable and bits 3:0 are the source code. The new routing shows at the outputs from that edge on.
- R3: A write presented while `cfg_mode` is low has no effect. The existing routing is unchanged.
- R4: Source code k selects output port k%2 of the cell at position k/2. The positions, as (row offset, column offset), are: 0 = (0,-1), 1 = (-1,0), 2 = (-1,-1), 3 = (0,-2), 4 = (-2,0) and 5 = (-1,+1).
- R5: Row and column offsets wrap modulo ROWS and COLS, so a link leaving one tile edge enters at the opposite edge.
- R6: An enabled entry with a code from 0 to 11 copies the selected source's data, address and valid to its destination port.
- R7: A disabled entry drives zero data, zero address and valid low on its destination port.
- R8: Codes 12 to 15 behave as a disabled entry, even when the enable bit is set.
- R9: `src_ready` of a source port is the AND of `dst_ready` over all destination ports currently selecting it. It is high when no port selects it.
- R10: One source port can feed several destination ports at once. Each of them receives the same data and address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 1 | High during the configuration phase |
| cfg_we | input | 1 | Routing entry write strobe |
| cfg_addr | input | 5 | Routing entry index, cell*2+port |
| cfg_wdata | input | 5 | Bit 4 enable, bits 3:0 source code |
| src_data | input | 256 | Data of every cell output port, port p at bits p*8+:8 |
| src_addr | input | 256 | Address of every cell output port |
| src_valid | input | 32 | Valid of every cell output port |
| src_ready | output | 32 | Returned ready for every cell output port |
| dst_data | output | 256 | Data delivered to every cell input port |
| dst_addr | output | 256 | Address delivered to every cell input port |
| dst_valid | output | 32 | Valid delivered to every cell input port |
| dst_ready | input | 32 | Ready from every cell input port |

## Verification
The checker watches several rules on every cycle:
- Routing entries stay frozen whenever the configuration phase is off.
- Disabled entries and entries holding out-of-range codes stay silent.
- Full downstream readiness always reaches every source.
- No destination shows valid unless some source does.

Other behaviours depend on the exact neighbour geometry and can only be shown by the bench's scenarios:
- Each code reaches the intended neighbour cell and port, including across the wrap-around edges.
- A write becomes visible in the cycle it should.
- The returned ready of a shared source falls when either listener stalls.

// File: rtl/quad_route_pkg.sv
package quad_route_pkg;

   localparam int PORTS_PER_CELL = 2;
   localparam int LINK_POS       = 6;
   localparam int CODE_COUNT     = LINK_POS * PORTS_PER_CELL;
   localparam int SEL_W          = 4;
   localparam int CFG_W          = SEL_W + 1;

   typedef struct packed {
      logic             en;
      logic [SEL_W-1:0] sel;
   } route_cfg_t;

   // Flat index of the source output port that code k names for a given
   // destination cell; offsets wrap at the tile edges.
   function automatic int src_slot(int rows, int cols, int dst_cell, int code);
      int r;
      int c;
      int sr;
      int sc;
      r = dst_cell / cols;
      c = dst_cell % cols;
      case (code / PORTS_PER_CELL)
         0:       begin sr = r;                    sc = (c + cols - 1) % cols; end
         1:       begin sr = (r + rows - 1) % rows; sc = c;                    end
         2:       begin sr = (r + rows - 1) % rows; sc = (c + cols - 1) % cols; end
         3:       begin sr = r;                    sc = (c + cols - 2) % cols; end
         4:       begin sr = (r + rows - 2) % rows; sc = c;                    end
         default: begin sr = (r + rows - 1) % rows; sc = (c + 1) % cols;        end
      endcase
      return (sr * cols + sc) * PORTS_PER_CELL + (code % PORTS_PER_CELL);
   endfunction

endpackage

// File: rtl/quad_route_cfg.sv
module quad_route_cfg
   import quad_route_pkg::*;
#(
   parameter int NPORT  = 32,
   parameter int CFG_AW = 5
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cfg_mode,
   input  logic                         cfg_we,
   input  logic [CFG_AW-1:0]            cfg_addr,
   input  logic [CFG_W-1:0]             cfg_wdata,
   output logic [NPORT-1:0][CFG_W-1:0]  cfg_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (cfg_mode && cfg_we) begin
         for (int i = 0; i < NPORT; i++) begin
            if (cfg_addr == CFG_AW'(i)) begin
               cfg_q[i] <= cfg_wdata;
            end
         end
      end
   end

endmodule

// File: rtl/quad_route_mux.sv
module quad_route_mux
   import quad_route_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 8
) (
   input  logic [CODE_COUNT-1:0][DW-1:0] cand_data,
   input  logic [CODE_COUNT-1:0][AW-1:0] cand_addr,
   input  logic [CODE_COUNT-1:0]         cand_valid,
   input  route_cfg_t                    cfg,
   output logic [DW-1:0]                 o_data,
   output logic [AW-1:0]                 o_addr,
   output logic                          o_valid,
   output logic [CODE_COUNT-1:0]         pick
);

   // One-hot decode; codes without a candidate leave pick empty.
   always_comb begin
      pick = '0;
      for (int k = 0; k < CODE_COUNT; k++) begin
         if (cfg.en && (cfg.sel == SEL_W'(k))) begin
            pick[k] = 1'b1;
         end
      end
   end

   // AND-OR selection: an empty pick yields all zeros.
   always_comb begin
      o_data  = '0;
      o_addr  = '0;
      o_valid = 1'b0;
      for (int k = 0; k < CODE_COUNT; k++) begin
         o_data  = o_data  | ({DW{pick[k]}} & cand_data[k]);
         o_addr  = o_addr  | ({AW{pick[k]}} & cand_addr[k]);
         o_valid = o_valid | (pick[k] & cand_valid[k]);
      end
   end

endmodule

// File: rtl/quad_route_ready.sv
module quad_route_ready #(
   parameter int NPORT = 32
) (
   input  logic [NPORT-1:0][NPORT-1:0] listen,
   input  logic [NPORT-1:0]            dst_ready,
   output logic [NPORT-1:0]            src_ready
);

   // listen[i][j]: destination i currently selects source j.
   always_comb begin
      src_ready = '1;
      for (int j = 0; j < NPORT; j++) begin
         for (int i = 0; i < NPORT; i++) begin
            if (listen[i][j] && !dst_ready[i]) begin
               src_ready[j] = 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/quad_route_fabric.sv
module quad_route_fabric
   import quad_route_pkg::*;
#(
   parameter  int ROWS   = 4,
   parameter  int COLS   = 4,
   parameter  int DW     = 8,
   parameter  int AW     = 8,
   localparam int NCELL  = ROWS * COLS,
   localparam int NPORT  = NCELL * PORTS_PER_CELL,
   localparam int CFG_AW = $clog2(NPORT)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_mode,
   input  logic                 cfg_we,
   input  logic [CFG_AW-1:0]    cfg_addr,
   input  logic [CFG_W-1:0]     cfg_wdata,
   input  logic [NPORT*DW-1:0]  src_data,
   input  logic [NPORT*AW-1:0]  src_addr,
   input  logic [NPORT-1:0]     src_valid,
   output logic [NPORT-1:0]     src_ready,
   output logic [NPORT*DW-1:0]  dst_data,
   output logic [NPORT*AW-1:0]  dst_addr,
   output logic [NPORT-1:0]     dst_valid,
   input  logic [NPORT-1:0]     dst_ready
);

   if (ROWS < 3 || COLS < 3) begin : g_bad_dims
      $error("quad_route_fabric: ROWS and COLS must be at least 3");
   end
   if (DW < 1 || AW < 1) begin : g_bad_width
      $error("quad_route_fabric: bus widths must be positive");
   end
   if (CODE_COUNT > (1 << SEL_W)) begin : g_bad_code
      $error("quad_route_fabric: source code field too narrow");
   end

   logic [NPORT-1:0][CFG_W-1:0]      cfg_q;
   logic [NPORT-1:0][CODE_COUNT-1:0] pick;
   logic [NPORT-1:0][NPORT-1:0]      listen;

   quad_route_cfg #(
      .NPORT  (NPORT),
      .CFG_AW (CFG_AW)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_mode  (cfg_mode),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_q     (cfg_q)
   );

   for (genvar i = 0; i < NPORT; i++) begin : g_dst
      logic [CODE_COUNT-1:0][DW-1:0] cand_data;
      logic [CODE_COUNT-1:0][AW-1:0] cand_addr;
      logic [CODE_COUNT-1:0]         cand_valid;

      for (genvar k = 0; k < CODE_COUNT; k++) begin : g_code
         localparam int SLOT = src_slot(ROWS, COLS, i / PORTS_PER_CELL, k);
         assign cand_data[k]  = src_data[SLOT*DW +: DW];
         assign cand_addr[k]  = src_addr[SLOT*AW +: AW];
         assign cand_valid[k] = src_valid[SLOT];
      end

      quad_route_mux #(
         .DW (DW),
         .AW (AW)
      ) u_mux (
         .cand_data  (cand_data),
         .cand_addr  (cand_addr),
         .cand_valid (cand_valid),
         .cfg        (route_cfg_t'(cfg_q[i])),
         .o_data     (dst_data[i*DW +: DW]),
         .o_addr     (dst_addr[i*AW +: AW]),
         .o_valid    (dst_valid[i]),
         .pick       (pick[i])
      );
   end

   // Map each destination's code pick onto the flat source index.
   always_comb begin
      listen = '0;
      for (int i = 0; i < NPORT; i++) begin
         for (int k = 0; k < CODE_COUNT; k++) begin
            listen[i][src_slot(ROWS, COLS, i / PORTS_PER_CELL, k)] =
               listen[i][src_slot(ROWS, COLS, i / PORTS_PER_CELL, k)] | pick[i][k];
         end
      end
   end

   quad_route_ready #(
      .NPORT (NPORT)
   ) u_rdy (
      .listen    (listen),
      .dst_ready (dst_ready),
      .src_ready (src_ready)
   );

endmodule

// File: rtl/quad_route_fabric_chk.sv
module quad_route_fabric_chk #(
   parameter int NPORT      = 32,
   parameter int DW         = 8,
   parameter int CFG_W      = 5,
   parameter int CODE_COUNT = 12
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        cfg_mode,
   input logic [NPORT-1:0][CFG_W-1:0] cfg_q,
   input logic [NPORT-1:0]            src_valid,
   input logic [NPORT-1:0]            src_ready,
   input logic [NPORT*DW-1:0]         dst_data,
   input logic [NPORT-1:0]            dst_valid,
   input logic [NPORT-1:0]            dst_ready
);

   // R3
   route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_mode |=> $stable(cfg_q));

   // R9
   ready_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&dst_ready) |-> (&src_ready));

   // R6
   valid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|dst_valid) |-> (|src_valid));

   for (genvar i = 0; i < NPORT; i++) begin : g_port
      // R7
      off_port_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !cfg_q[i][CFG_W-1] |-> (!dst_valid[i] && (dst_data[i*DW +: DW] == '0)));

      // R8
      bad_code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (int'(cfg_q[i][CFG_W-2:0]) >= CODE_COUNT) |-> !dst_valid[i]);
   end

endmodule

bind quad_route_fabric quad_route_fabric_chk #(
   .NPORT      (NPORT),
   .DW         (DW),
   .CFG_W      (quad_route_pkg::CFG_W),
   .CODE_COUNT (quad_route_pkg::CODE_COUNT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_mode  (cfg_mode),
   .cfg_q     (cfg_q),
   .src_valid (src_valid),
   .src_ready (src_ready),
   .dst_data  (dst_data),
   .dst_valid (dst_valid),
   .dst_ready (dst_ready)
);

// File: tb/quad_route_fabric_test.sv
module quad_route_fabric_test;

   localparam int CLK_PERIOD = 10;
   localparam int NPORT      = 32;
   localparam int DW         = 8;
   localparam int NVEC       = 10;

   typedef struct packed {
      logic [4:0] dst;
      logic [3:0] code;
      logic [4:0] src;
   } vec_t;

   // Expected source index worked out by hand from R4/R5 on the 4x4 tile.
   localparam vec_t VEC [NVEC] = '{
      '{5'd10, 4'd0,  5'd8 },
      '{5'd11, 4'd3,  5'd3 },
      '{5'd0,  4'd4,  5'd30},
      '{5'd1,  4'd7,  5'd5 },
      '{5'd24, 4'd9,  5'd9 },
      '{5'd6,  4'd10, 5'd24},
      '{5'd21, 4'd11, 5'd15},
      '{5'd16, 4'd1,  5'd23},
      '{5'd31, 4'd5,  5'd21},
      '{5'd12, 4'd2,  5'd4 }
   };

   logic                clk = 1'b0;
   logic                rst_n;
   logic                cfg_mode;
   logic                cfg_we;
   logic [4:0]          cfg_addr;
   logic [4:0]          cfg_wdata;
   logic [NPORT*DW-1:0] src_data;
   logic [NPORT*DW-1:0] src_addr;
   logic [NPORT-1:0]    src_valid;
   logic [NPORT-1:0]    src_ready;
   logic [NPORT*DW-1:0] dst_data;
   logic [NPORT*DW-1:0] dst_addr;
   logic [NPORT-1:0]    dst_valid;
   logic [NPORT-1:0]    dst_ready;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   quad_route_fabric uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_mode  (cfg_mode),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .src_data  (src_data),
      .src_addr  (src_addr),
      .src_valid (src_valid),
      .src_ready (src_ready),
      .dst_data  (dst_data),
      .dst_addr  (dst_addr),
      .dst_valid (dst_valid),
      .dst_ready (dst_ready)
   );

   function automatic logic [7:0] pat_d(int p);
      return 8'(p * 37 + 11);
   endfunction

   function automatic logic [7:0] pat_a(int p);
      return 8'(p * 59 + 5);
   endfunction

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic set_route(input int dst, input bit en, input int code, input bit mode);
      @(negedge clk);
      cfg_mode  = mode;
      cfg_we    = 1'b1;
      cfg_addr  = 5'(dst);
      cfg_wdata = {en, 4'(code)};
      @(negedge clk);
      cfg_we    = 1'b0;
      cfg_mode  = 1'b0;
      #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n     = 1'b0;
      cfg_mode  = 1'b0;
      cfg_we    = 1'b0;
      cfg_addr  = '0;
      cfg_wdata = '0;
      src_valid = '1;
      dst_ready = '1;
      for (int p = 0; p < NPORT; p++) begin
         src_data[p*DW +: DW] = pat_d(p);
         src_addr[p*DW +: DW] = pat_a(p);
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;

      // R1: reset state
      chk("R1 dst_valid", dst_valid, 0);
      chk("R1 dst_data", (dst_data == '0), 1);
      chk("R1 dst_addr", (dst_addr == '0), 1);
      chk("R1 src_ready", src_ready, 32'hFFFF_FFFF);

      // Table walk: R4 code map, R5 wrap, R6 copy, R9 ready, R7 disable
      for (int v = 0; v < NVEC; v++) begin
         set_route(int'(VEC[v].dst), 1'b1, int'(VEC[v].code), 1'b1);
         src_valid = '0;
         src_valid[VEC[v].src] = 1'b1;
         dst_ready = '1;
         dst_ready[VEC[v].dst] = 1'b0;
         #1;
         chk("R4 R5 R6 data", dst_data[VEC[v].dst*DW +: DW], pat_d(int'(VEC[v].src)));
         chk("R4 R5 R6 addr", dst_addr[VEC[v].dst*DW +: DW], pat_a(int'(VEC[v].src)));
         chk("R6 valid", dst_valid[VEC[v].dst], 1);
         chk("R9 stalled ready", src_ready[VEC[v].src], 0);
         dst_ready = '1;
         #1;
         chk("R9 free ready", src_ready[VEC[v].src], 1);
         set_route(int'(VEC[v].dst), 1'b0, int'(VEC[v].code), 1'b1);
         src_valid = '1;
         #1;
         chk("R7 off valid", dst_valid[VEC[v].dst], 0);
         chk("R7 off data", dst_data[VEC[v].dst*DW +: DW], 0);
      end

      // R2: write timing, dst 20 (cell 10 port 0) code 0 -> source 18
      src_valid = '1;
      @(negedge clk);
      cfg_mode  = 1'b1;
      cfg_we    = 1'b1;
      cfg_addr  = 5'd20;
      cfg_wdata = {1'b1, 4'd0};
      #1;
      chk("R2 before edge", dst_valid[20], 0);
      @(negedge clk);
      cfg_we   = 1'b0;
      cfg_mode = 1'b0;
      #1;
      chk("R2 after edge", dst_data[20*DW +: DW], pat_d(18));
      chk("R2 valid after edge", dst_valid[20], 1);

      // R3: writes with cfg_mode low are dropped
      set_route(20, 1'b0, 0, 1'b0);
      chk("R3 route kept", dst_data[20*DW +: DW], pat_d(18));
      set_route(22, 1'b1, 0, 1'b0);
      chk("R3 no new route", dst_valid[22], 0);

      // R8: out-of-range codes stay silent
      set_route(21, 1'b1, 13, 1'b1);
      chk("R8 code 13 valid", dst_valid[21], 0);
      chk("R8 code 13 data", dst_data[21*DW +: DW], 0);
      set_route(21, 1'b1, 12, 1'b1);
      chk("R8 code 12 valid", dst_valid[21], 0);

      // R10: dst 26 (cell 13 port 0) code 2 also selects source 18
      set_route(26, 1'b1, 2, 1'b1);
      chk("R10 first listener", dst_data[20*DW +: DW], pat_d(18));
      chk("R10 second listener", dst_data[26*DW +: DW], pat_d(18));
      chk("R10 second addr", dst_addr[26*DW +: DW], pat_a(18));
      dst_ready = '1;
      #1;
      chk("R9 both ready", src_ready[18], 1);
      dst_ready[26] = 1'b0;
      #1;
      chk("R9 second stalls", src_ready[18], 0);
      dst_ready[26] = 1'b1;
      dst_ready[20] = 1'b0;
      #1;
      chk("R9 first stalls", src_ready[18], 0);
      dst_ready = '0;
      #1;
      chk("R9 no listener", src_ready[0], 1);
      chk("R9 shared all stalled", src_ready[18], 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule